// File: doc/BRIEF.md
# Burst Protocol Violation Checker

This block sits behind the word aligner of a 16-bit packet-over-lanes receiver. It watches the decoded word stream and raises a one-cycle pulse for each class of framing or protocol violation it sees. Each accepted word comes with a strobe and a flag that marks it as a control word or a data word. The checker decodes payload control words to find the start-of-packet bit, the end-of-packet status and the port address. It counts data words per burst and measures the distance between start-of-packet indications. A small state machine with idle, in-burst and training states tracks where the stream is.

A control word has this layout. Bit 15 is the payload flag. Bits 14:13 hold the end status: 00 means no end, 01 means abort, 10 means the packet ends with two valid bytes, 11 means it ends with one valid byte. Bit 12 marks a packet start, bits 11:4 carry the port address and bits 3:0 are parity, which this block ignores. A non-payload control word has one of three meanings. With the start bit clear and a zero address it is an idle word; its end status still applies. The exact value 16'h0FFF is a training word. Anything else is reserved. Any idle or payload control word closes an open burst, and a payload control word also opens a new one.

Top module: `burst_chk_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, all outputs are low. The tracker starts in the idle state with no burst open and no packet start seen.
- R2: `errSopGap` pulses when a payload control word with bit 12 set arrives fewer than `MIN_SOP_GAP` (default 8) accepted words after the previous such word. Its distance is 1 when it immediately follows. The very first start after reset never flags.
- R3: `errBurstLen` pulses when an idle or payload control word with end status 00 closes an open burst whose data-word count is not a multiple of `BURST_WORDS` (default 8 words, 16 bytes).
- R4: `errBurstStart` pulses for each data word that arrives in the idle state. Data words in the training state are not flagged.
- R5: `errPadByte` pulses when end status 11 closes a burst that holds at least one data word and the low byte (bits 7:0) of its last data word is non-zero.
- R6: `statAbort` pulses when end status 01 closes an open burst.
- R7: `statReserved` pulses for a reserved control word. The word does not change the state, the open burst, or its word count.
- R8: `errAddr` pulses for a payload control word whose address field (bits 11:4) exceeds `MAX_PORT`. The burst still opens.
- R9: `errProtocol` pulses in two cases. One is an idle or payload control word with a non-zero end status when no burst is open. The other is a training word (16'h0FFF) that arrives while a burst is open.
- R10: Every output is high for exactly the one cycle after the clock edge that accepts the causing word. A cycle with `wordValid` low causes no pulse and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | Word on `wordData` is accepted this cycle |
| wordCtrl | input | 1 | High: control word; low: data word |
| wordData | input | 16 | Decoded word |
| errSopGap | output | 1 | Packet starts too close together |
| errBurstLen | output | 1 | Burst closed without end at a bad length |
| errBurstStart | output | 1 | Data word outside a burst |
| errPadByte | output | 1 | Non-zero pad byte on an odd-length end |
| statAbort | output | 1 | Packet end with abort |
| statReserved | output | 1 | Reserved control word seen |
| errAddr | output | 1 | Port address above `MAX_PORT` |
| errProtocol | output | 1 | Illegal state-machine transition |

## Verification
The hardest situations to reach from the ports are those where one word both closes a burst and opens the next. In those cases the length, pad and gap checks must all use the old burst's counts, while the new counts start from zero. Reserved words that fall inside an open burst are another, since they must leave the word count untouched. Directed sequences build these cases explicitly: back-to-back payload words, a reserved word between data words, and a training word that cuts a burst. After that comes a long stream of weighted random words with idle gaps. A behavioural model in the bench compares all eight pulses on every clock.

// File: rtl/burst_chk_pkg.sv
package burst_chk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_TRAIN = 2'd2
  } trkState_t;

  localparam logic [1:0] END_NONE  = 2'b00;
  localparam logic [1:0] END_ABORT = 2'b01;
  localparam logic [1:0] END_TWO   = 2'b10;
  localparam logic [1:0] END_ONE   = 2'b11;

  localparam logic [15:0] TRAIN_WORD = 16'h0FFF;

  // Strobes from control to datapath, valid for the current accepted word.
  typedef struct packed {
    logic wordTick;   // any accepted word
    logic dataWord;   // data word counted in an open burst
    logic openBurst;  // payload control word starts a new burst
    logic sopEvt;     // payload control word with start bit
    logic closeChk;   // burst closed with no end: length check
    logic padChk;     // burst closed with single valid byte: pad check
    logic abortEvt;
    logic protoErr;
    logic badStart;
    logic addrErr;
    logic rsvdEvt;
  } ctlStrobe_t;

endpackage

// File: rtl/burst_chk_ctrl.sv
module burst_chk_ctrl
  import burst_chk_pkg::*;
#(
  parameter int MAX_PORT = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wordValid,
  input  logic        wordCtrl,
  input  logic [15:0] wordData,
  output ctlStrobe_t  strb
);

  localparam logic [7:0] MAX_ADDR = 8'(MAX_PORT);

  trkState_t state, stateNxt;

  logic       isCtl;
  logic       fPayload;
  logic [1:0] fEnd;
  logic       fSop;
  logic [7:0] fAddr;
  logic       isTrain, isIdle, isPay, isRsvd;
  logic       inBurst, closing;

  always_comb begin
    isCtl    = wordValid & wordCtrl;
    fPayload = wordData[15];
    fEnd     = wordData[14:13];
    fSop     = wordData[12];
    fAddr    = wordData[11:4];
    isTrain  = isCtl & (wordData == TRAIN_WORD);
    isIdle   = isCtl & ~fPayload & ~fSop & (fAddr == 8'h00);
    isPay    = isCtl & fPayload;
    isRsvd   = isCtl & ~fPayload & ~isTrain & ~isIdle;
    inBurst  = (state == ST_BURST);
    closing  = (isIdle | isPay) & inBurst;
  end

  always_comb begin
    strb.wordTick  = wordValid;
    strb.dataWord  = wordValid & ~wordCtrl & inBurst;
    strb.badStart  = wordValid & ~wordCtrl & (state == ST_IDLE);
    strb.openBurst = isPay;
    strb.sopEvt    = isPay & fSop;
    strb.addrErr   = isPay & (fAddr > MAX_ADDR);
    strb.closeChk  = closing & (fEnd == END_NONE);
    strb.padChk    = closing & (fEnd == END_ONE);
    strb.abortEvt  = closing & (fEnd == END_ABORT);
    strb.protoErr  = ((isIdle | isPay) & ~inBurst & (fEnd != END_NONE))
                   | (isTrain & inBurst);
    strb.rsvdEvt   = isRsvd;
  end

  always_comb begin
    stateNxt = state;
    if (isPay)        stateNxt = ST_BURST;
    else if (isIdle)  stateNxt = ST_IDLE;
    else if (isTrain) stateNxt = ST_TRAIN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

endmodule

// File: rtl/burst_chk_dp.sv
module burst_chk_dp
  import burst_chk_pkg::*;
#(
  parameter int MIN_SOP_GAP = 8,
  parameter int BURST_WORDS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ctlStrobe_t strb,
  input  logic [7:0] dataLow,
  output logic       errSopGap,
  output logic       errBurstLen,
  output logic       errBurstStart,
  output logic       errPadByte,
  output logic       statAbort,
  output logic       statReserved,
  output logic       errAddr,
  output logic       errProtocol
);

  localparam int MOD_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
  localparam int GAP_W = $clog2(MIN_SOP_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MIN_SOP_GAP);
  localparam logic [MOD_W-1:0] MOD_TOP = MOD_W'(BURST_WORDS - 1);
  localparam bit   POW2 = (BURST_WORDS & (BURST_WORDS - 1)) == 0;

  logic [MOD_W-1:0] wordMod, wordModInc;
  logic             haveData;
  logic [7:0]       lastLow;
  logic [GAP_W-1:0] sopGap;
  logic             sopSeen;

  // Burst length is kept only modulo the granularity.
  generate
    if (POW2 && BURST_WORDS > 1) begin : g_modPow2
      assign wordModInc = wordMod + MOD_W'(1);
    end else begin : g_modWrap
      assign wordModInc = (wordMod == MOD_TOP) ? '0 : wordMod + MOD_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordMod  <= '0;
      haveData <= 1'b0;
      lastLow  <= '0;
    end else if (strb.openBurst) begin
      wordMod  <= '0;
      haveData <= 1'b0;
    end else if (strb.dataWord) begin
      wordMod  <= wordModInc;
      haveData <= 1'b1;
      lastLow  <= dataLow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sopGap  <= '0;
      sopSeen <= 1'b0;
    end else if (strb.sopEvt) begin
      sopGap  <= GAP_W'(1);
      sopSeen <= 1'b1;
    end else if (strb.wordTick && sopGap < GAP_LIM) begin
      sopGap  <= sopGap + GAP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      errSopGap     <= 1'b0;
      errBurstLen   <= 1'b0;
      errBurstStart <= 1'b0;
      errPadByte    <= 1'b0;
      statAbort     <= 1'b0;
      statReserved  <= 1'b0;
      errAddr       <= 1'b0;
      errProtocol   <= 1'b0;
    end else begin
      errSopGap     <= strb.sopEvt & sopSeen & (sopGap < GAP_LIM);
      errBurstLen   <= strb.closeChk & (wordMod != '0);
      errBurstStart <= strb.badStart;
      errPadByte    <= strb.padChk & haveData & (lastLow != 8'h00);
      statAbort     <= strb.abortEvt;
      statReserved  <= strb.rsvdEvt;
      errAddr       <= strb.addrErr;
      errProtocol   <= strb.protoErr;
    end
  end

endmodule

// File: rtl/burst_chk_top.sv
module burst_chk_top
  import burst_chk_pkg::*;
#(
  parameter int MAX_PORT    = 63,
  parameter int MIN_SOP_GAP = 8,
  parameter int BURST_WORDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wordValid,
  input  logic        wordCtrl,
  input  logic [15:0] wordData,
  output logic        errSopGap,
  output logic        errBurstLen,
  output logic        errBurstStart,
  output logic        errPadByte,
  output logic        statAbort,
  output logic        statReserved,
  output logic        errAddr,
  output logic        errProtocol
);

  ctlStrobe_t strb;

  burst_chk_ctrl #(.MAX_PORT(MAX_PORT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wordValid (wordValid),
    .wordCtrl  (wordCtrl),
    .wordData  (wordData),
    .strb      (strb)
  );

  burst_chk_dp #(
    .MIN_SOP_GAP (MIN_SOP_GAP),
    .BURST_WORDS (BURST_WORDS)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strb          (strb),
    .dataLow       (wordData[7:0]),
    .errSopGap     (errSopGap),
    .errBurstLen   (errBurstLen),
    .errBurstStart (errBurstStart),
    .errPadByte    (errPadByte),
    .statAbort     (statAbort),
    .statReserved  (statReserved),
    .errAddr       (errAddr),
    .errProtocol   (errProtocol)
  );

endmodule

// File: rtl/burst_chk_sva.sv
module burst_chk_sva #(
  parameter int MAX_PORT = 63
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wordValid,
  input logic        wordCtrl,
  input logic [15:0] wordData,
  input logic        errSopGap,
  input logic        errBurstLen,
  input logic        errBurstStart,
  input logic        errPadByte,
  input logic        statAbort,
  input logic        statReserved,
  input logic        errAddr,
  input logic        errProtocol
);

  logic anyOut;
  assign anyOut = errSopGap | errBurstLen | errBurstStart | errPadByte |
                  statAbort | statReserved | errAddr | errProtocol;

  // R2
  sop_gap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errSopGap |-> $past(wordValid && wordCtrl && wordData[15] && wordData[12]));

  // R3
  len_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errBurstLen |-> $past(wordValid && wordCtrl && wordData[14:13] == 2'b00));

  // R4
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errBurstStart |-> $past(wordValid && !wordCtrl));

  // R5
  pad_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errPadByte |-> $past(wordValid && wordCtrl && wordData[14:13] == 2'b11));

  // R6
  abort_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    statAbort |-> $past(wordValid && wordCtrl && wordData[14:13] == 2'b01));

  // R7
  rsvd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    statReserved |-> $past(wordValid && wordCtrl && !wordData[15]));

  // R8
  addr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errAddr |-> $past(wordValid && wordCtrl && wordData[15] &&
                      (int'(wordData[11:4]) > MAX_PORT)));

  // R9
  proto_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errProtocol |-> $past(wordValid && wordCtrl));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wordValid |=> !anyOut);

  // R10
  data_only_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wordValid && !wordCtrl) |=> !(errSopGap | errBurstLen | errPadByte |
                                   statAbort | statReserved | errAddr | errProtocol));

endmodule

bind burst_chk_top burst_chk_sva #(.MAX_PORT(MAX_PORT)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .wordValid     (wordValid),
  .wordCtrl      (wordCtrl),
  .wordData      (wordData),
  .errSopGap     (errSopGap),
  .errBurstLen   (errBurstLen),
  .errBurstStart (errBurstStart),
  .errPadByte    (errPadByte),
  .statAbort     (statAbort),
  .statReserved  (statReserved),
  .errAddr       (errAddr),
  .errProtocol   (errProtocol)
);

// File: tb/burst_chk_top_tb.sv
module burst_chk_top_tb;

  localparam int MAXP = 63;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wordValid = 1'b0;
  logic        wordCtrl = 1'b0;
  logic [15:0] wordData = 16'h0000;
  logic errSopGap, errBurstLen, errBurstStart, errPadByte;
  logic statAbort, statReserved, errAddr, errProtocol;

  burst_chk_top #(.MAX_PORT(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wordValid(wordValid), .wordCtrl(wordCtrl),
    .wordData(wordData), .errSopGap(errSopGap), .errBurstLen(errBurstLen),
    .errBurstStart(errBurstStart), .errPadByte(errPadByte),
    .statAbort(statAbort), .statReserved(statReserved), .errAddr(errAddr),
    .errProtocol(errProtocol)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit armed  = 0;
  bit finished = 0;

  // Reference model (behavioural)
  int mState = 0;      // 0 idle, 1 burst, 2 training
  int mCount = 0;      // data words in open burst
  int mLow   = 0;
  int mSeen  = 0;
  int mGap   = 0;
  bit prevValid = 0;
  logic [7:0] expv = '0; // {sop,len,start,pad,abort,rsvd,addr,proto}

  string tags [8] = '{"R9 protocol", "R8 address", "R7 reserved", "R6 abort",
                      "R5 pad byte", "R4 burst start", "R3 burst length", "R2 sop gap"};

  always @(posedge clk) begin
    armed <= 1'b1;
    prevValid <= rst_n && wordValid;
    if (!rst_n) begin
      mState = 0; mCount = 0; mLow = 0; mSeen = 0; mGap = 0;
      expv = '0;
    end else begin
      expv = '0;
      if (wordValid) begin
        if (!wordCtrl) begin
          if (mState == 0) expv[5] = 1'b1;
          else if (mState == 1) begin
            mCount = mCount + 1;
            mLow = int'(wordData[7:0]);
          end
        end else begin
          automatic bit pay  = wordData[15];
          automatic int eopS = int'(wordData[14:13]);
          automatic bit sop  = wordData[12];
          automatic int adr  = int'(wordData[11:4]);
          automatic bit trn  = (wordData == 16'h0FFF);
          automatic bit idl  = !pay && !sop && adr == 0;
          if (!pay && !trn && !idl) expv[2] = 1'b1;
          else if (trn) begin
            if (mState == 1) expv[0] = 1'b1;
            mState = 2;
          end else begin
            if (mState == 1) begin
              if (eopS == 0 && (mCount % 8) != 0) expv[6] = 1'b1;
              if (eopS == 1) expv[3] = 1'b1;
              if (eopS == 3 && mCount > 0 && mLow != 0) expv[4] = 1'b1;
            end else if (eopS != 0) expv[0] = 1'b1;
            if (pay) begin
              if (adr > MAXP) expv[1] = 1'b1;
              if (sop && mSeen != 0 && mGap < 8) expv[7] = 1'b1;
              mState = 1; mCount = 0; mLow = 0;
            end else mState = 0;
          end
        end
        if (wordCtrl && wordData[15] && wordData[12]) begin
          mSeen = 1; mGap = 1;
        end else if (mGap < 8) mGap = mGap + 1;
      end
    end
  end

  wire [7:0] act = {errSopGap, errBurstLen, errBurstStart, errPadByte,
                    statAbort, statReserved, errAddr, errProtocol};

  always @(negedge clk) begin
    if (armed && !finished) begin
      for (int i = 0; i < 8; i++) begin
        checks++;
        if (act[i] !== expv[i]) begin
          fails++;
          $display("FAIL %s at %0t: actual=%b expected=%b", tags[i], $time, act[i], expv[i]);
        end
      end
      if (rst_n && !prevValid) begin
        checks++;
        if (act !== 8'h00) begin
          fails++;
          $display("FAIL R10 pulse after empty cycle: actual=%b expected=00000000", act);
        end
      end
    end
  end

  function automatic logic [15:0] pcw(input logic [1:0] e, input logic s, input logic [7:0] a);
    return {1'b1, e, s, a, 4'h5};
  endfunction
  function automatic logic [15:0] icw(input logic [1:0] e);
    return {1'b0, e, 1'b0, 8'h00, 4'hA};
  endfunction

  task automatic send(input logic c, input logic [15:0] d);
    @(negedge clk);
    wordValid = 1'b1; wordCtrl = c; wordData = d;
  endtask
  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wordValid = 1'b0; wordData = $urandom;
    end
  endtask
  task automatic dataN(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) send(1'b0, base + 16'(i));
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs low throughout reset (compared each cycle)
    rst_n = 1'b1;
    gap(1);
    // R1 / R4: idle after reset, a data word flags a start error
    send(1'b0, 16'h1111);
    gap(1);
    // R10 field layout use, R3: 8 words clean, then 3 words closed with no end
    send(1'b1, pcw(2'b00, 1'b1, 8'd1));
    dataN(8, 16'h0100);
    send(1'b1, pcw(2'b10, 1'b1, 8'd2));
    dataN(3, 16'h0200);
    send(1'b1, icw(2'b00));
    gap(2);
    // R2: starts two words apart, then exactly eight apart
    send(1'b1, pcw(2'b00, 1'b1, 8'd3));
    dataN(1, 16'h0300);
    send(1'b1, pcw(2'b00, 1'b1, 8'd3));
    dataN(7, 16'h0310);
    send(1'b1, pcw(2'b00, 1'b1, 8'd3));
    // R5: one data word with non-zero low byte, then with zero low byte
    dataN(1, 16'h1234);
    send(1'b1, icw(2'b11));
    send(1'b1, pcw(2'b00, 1'b0, 8'd4));
    send(1'b0, 16'h1200);
    send(1'b1, icw(2'b11));
    // R6: abort closes a burst
    send(1'b1, pcw(2'b00, 1'b0, 8'd5));
    dataN(2, 16'h0500);
    send(1'b1, pcw(2'b01, 1'b0, 8'd5));
    // R7: reserved word inside burst keeps state and count
    dataN(4, 16'h0600);
    send(1'b1, 16'h1005);
    dataN(4, 16'h0610);
    send(1'b1, icw(2'b00));
    // R8: address above max and at max
    send(1'b1, pcw(2'b00, 1'b0, 8'd200));
    send(1'b1, pcw(2'b00, 1'b0, 8'(MAXP)));
    send(1'b1, icw(2'b00));
    // R9: end status with no burst open; training word cutting a burst
    send(1'b1, icw(2'b10));
    send(1'b1, pcw(2'b11, 1'b0, 8'd6));
    dataN(2, 16'h0700);
    send(1'b1, 16'h0FFF);
    // R4: data in training state not flagged
    dataN(3, 16'h0800);
    send(1'b1, icw(2'b00));
    gap(2);
    // Weighted random stream
    for (int n = 0; n < 3000; n++) begin
      automatic int k = $urandom_range(0, 99);
      if (k < 50) send(1'b0, 16'($urandom));
      else if (k < 70) send(1'b1, pcw(2'($urandom), 1'($urandom), 8'($urandom_range(0, 80))));
      else if (k < 80) send(1'b1, icw(2'($urandom)));
      else if (k < 84) send(1'b1, 16'h0FFF);
      else if (k < 88) send(1'b1, {1'b0, 15'($urandom)});
      else gap($urandom_range(1, 3));
    end
    gap(3);
    summary();
  end

endmodule